// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked on-chip requester and an external asynchronous static RAM of 65,536 words by 16 bits. The requester presents an address, a write flag, a 16-bit write word and a two-bit lane mask on a valid/ready handshake. The controller turns each request into one access on the memory pins. It drives active-low chip select, output enable, write strobe and one enable per byte lane. The data bus is presented as a drive value, a single drive-enable and a sampled input, so that the pad tristate lives outside the block. A read comes back to the requester as a one-cycle response pulse with the read word.

The memory's nanosecond minimums are turned into whole clock counts when the block is elaborated. The counts come from a clock-period parameter and a speed-grade parameter, and each is rounded up to at least one cycle. Back-pressure is simple: `req_ready` is high only while the controller is idle. A request counts as taken on the edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. `req_ready` then stays low until the access, including its closing cycle, is complete. The response interface has no ready signal, so the requester must accept every response pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and directly after it, chip select, output enable, write strobe and both lane enables are high, the bus drive-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the controller is idle again, and it is never high while any memory enable is low.
- R3: During a write, the bus drive-enable rises only after the write strobe has been low for the turnaround count of cycles. It stays high through the cycle in which the write strobe returns high, with chip select still low, and it falls on the next edge. The driven word equals the request's write data.
- R4: During an access, lane enable bit 0 is the inverse of mask bit 0 and covers data bits 7:0. Lane enable bit 1 is the inverse of mask bit 1 and covers bits 15:8. `mem_addr` equals the request address.
- R5: A read holds output enable low and the write strobe high. `rsp_valid` pulses for exactly one cycle, in the cycle in which output enable returns high. `rsp_rdata` carries the bus as sampled on the last read cycle, with the lanes whose mask bit is 0 returned as zero.
- R6: A request with mask 00 enables no lane. Such a write leaves the stored word unchanged, and such a read returns zero.
- R7: While chip select stays low, `mem_addr` and the lane enables do not change.
- R8: Every access is preceded by at least one cycle with chip select, output enable, write strobe and both lane enables all high.
- R9: Write strobe and output enable are never low together, and the bus is driven only while chip select is low.
- R10: The write strobe stays low for max(ceil(tWP), ceil(tWHZ)+ceil(tDW), ceil(tWC)-1) cycles. The turnaround count is ceil(tWHZ). Output enable stays low for max(ceil(tAA), ceil(tOE)) cycles. Each ceiling is the time divided by the clock period, at least 1. The fast grade uses tWP 10 ns, tDW 6 ns, tWC 12 ns, tWHZ 6 ns, tAA 12 ns and tOE 6 ns; the slow grade uses 12, 7, 15, 8, 15 and 8 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_mask | input | DATA_W/8 | Lane select, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W | Read word, unselected lanes zero |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DATA_W/8 | Lane enables, active low, bit 0 = bits 7:0 |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Value to drive on the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data bus as sampled |

## Verification
With a 20 ns clock and the fast grade, the write strobe is low for two cycles. The bus is driven from the second of those cycles through the following cycle, so a write ends three edges after acceptance. A read holds output enable for one cycle, and the response pulse and the return of all enables to high appear together one edge after acceptance. The bench samples every output on the falling clock edge. It checks each pin and response relative to the edge that accepted the request, by counting strobe-low runs and watching for transitions rather than waiting a fixed time. A queue of expected read words is filled when each read is issued and is emptied one entry per response pulse.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_WRITE = 2'd1,
    SC_WREND = 2'd2,
    SC_READ  = 2'd3
  } sc_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } sc_ctl_t;

  localparam sc_ctl_t SC_CTL_REST = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  // Round a time up to whole clock periods, never below one cycle.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned q;
    q = (t_ps + clk_ps - 1) / clk_ps;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned W_CYC    = 2,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned R_CYC    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [LANES-1:0] start_sel,
  output logic             idle,
  output sc_ctl_t          ctl,
  output logic [LANES-1:0] be_n,
  output logic             cap
);

  localparam int unsigned CW = $clog2(umax(W_CYC, R_CYC) + 1);

  sc_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  sc_ctl_t          ctl_d;
  logic [LANES-1:0] be_n_d;

  assign idle = (state_q == SC_IDLE);
  assign cap  = (state_q == SC_READ) && (cnt_q == CW'(R_CYC - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ctl_d   = ctl;
    be_n_d  = be_n;
    unique case (state_q)
      SC_IDLE: begin
        if (start) begin
          cnt_d      = '0;
          be_n_d     = ~start_sel;
          ctl_d.ce_n = 1'b0;
          if (start_wr) begin
            state_d    = SC_WRITE;
            ctl_d.we_n = 1'b0;
          end else begin
            state_d    = SC_READ;
            ctl_d.oe_n = 1'b0;
          end
        end
      end
      SC_WRITE: begin
        if (cnt_q == CW'(W_CYC - 1)) begin
          state_d     = SC_WREND;
          ctl_d.we_n  = 1'b1;
          ctl_d.dq_oe = 1'b1;
        end else begin
          cnt_d       = cnt_q + 1'b1;
          ctl_d.dq_oe = (cnt_d >= CW'(TURN_CYC));
        end
      end
      SC_WREND: begin
        state_d = SC_IDLE;
        ctl_d   = SC_CTL_REST;
        be_n_d  = '1;
      end
      SC_READ: begin
        if (cap) begin
          state_d = SC_IDLE;
          ctl_d   = SC_CTL_REST;
          be_n_d  = '1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = SC_IDLE;
        ctl_d   = SC_CTL_REST;
        be_n_d  = '1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      cnt_q   <= '0;
      ctl     <= SC_CTL_REST;
      be_n    <= '1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ctl     <= ctl_d;
      be_n    <= be_n_d;
    end
  end

endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sel_in,
  input  logic [LW-1:0] wbyte_in,
  input  logic          cap,
  input  logic [LW-1:0] bus_in,
  output logic [LW-1:0] wbyte,
  output logic [LW-1:0] rbyte
);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wbyte <= '0;
      rbyte <= '0;
    end else begin
      if (load) begin
        sel_q <= sel_in;
        wbyte <= wbyte_in;
      end
      if (cap) rbyte <= sel_q ? bus_in : '0;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_PS     = 20000,
  parameter bit          FAST_GRADE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int unsigned LANES = DATA_W / 8;

  // Minimum times in picoseconds for the selected grade.
  localparam int unsigned T_WP  = FAST_GRADE ? 10000 : 12000;
  localparam int unsigned T_DW  = FAST_GRADE ?  6000 :  7000;
  localparam int unsigned T_WC  = FAST_GRADE ? 12000 : 15000;
  localparam int unsigned T_WHZ = FAST_GRADE ?  6000 :  8000;
  localparam int unsigned T_AA  = FAST_GRADE ? 12000 : 15000;
  localparam int unsigned T_OE  = FAST_GRADE ?  6000 :  8000;

  localparam int unsigned C_TURN = ps_to_cyc(T_WHZ, CLK_PS);
  localparam int unsigned C_WR   = umax(umax(ps_to_cyc(T_WP, CLK_PS),
                                           C_TURN + ps_to_cyc(T_DW, CLK_PS)),
                                      ps_to_cyc(T_WC, CLK_PS) - 1);
  localparam int unsigned C_RD   = umax(ps_to_cyc(T_AA, CLK_PS), ps_to_cyc(T_OE, CLK_PS));

  logic    accept;
  logic    idle;
  logic    cap;
  sc_ctl_t ctl;

  assign req_ready = idle;
  assign accept    = req_valid & idle;

  sram_ctl_seq #(
    .LANES   (LANES),
    .W_CYC   (C_WR),
    .TURN_CYC(C_TURN),
    .R_CYC   (C_RD)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .start_sel(req_mask),
    .idle     (idle),
    .ctl      (ctl),
    .be_n     (mem_be_n),
    .cap      (cap)
  );

  assign mem_ce_n  = ctl.ce_n;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_dq_oe = ctl.dq_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) mem_addr <= req_addr;
      rsp_valid <= cap;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_ctl_lane #(.LW(8)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .sel_in  (req_mask[g]),
      .wbyte_in(req_wdata[8*g +: 8]),
      .cap     (cap),
      .bus_in  (mem_dq_in[8*g +: 8]),
      .wbyte   (mem_dq_out[8*g +: 8]),
      .rbyte   (rsp_rdata[8*g +: 8])
    );
  end

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R9

  AST_DRIVE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n); // R9

  AST_DRIVE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n))); // R3

  AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_oe); // R3

  AST_DRIVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |=> !mem_dq_oe); // R3

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n))); // R7

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(mem_we_n && mem_oe_n && (&mem_be_n))); // R8

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n)); // R2

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W),
  .LANES (DATA_W / 8)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_be_n (mem_be_n),
  .mem_addr (mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

  // Expected counts at 20 ns, fast grade (R10): strobe 2, turnaround 1, read 1.
  localparam int EXP_WR   = 2;
  localparam int EXP_TURN = 1;
  localparam int EXP_RD   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hA5A5;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] sram   [int];
  logic [15:0] shadow [int];
  logic [15:0] expq   [$];
  logic [15:0] last_addr, last_wdata;
  logic [1:0]  last_mask;

  always #10 clk = ~clk;

  sram_ctl #(.CLK_PS(20000), .FAST_GRADE(1'b1)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_bits(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Driver: issues one request, records the expected result.
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] old;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    last_addr = a; last_wdata = d; last_mask = m;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (wr) shadow[int'(a)] = (old & ~lane_bits(m)) | (d & lane_bits(m));
    else    expq.push_back(old & lane_bits(m));
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
  endtask

  // Behavioural memory, updated between edges.
  always @(negedge clk) begin
    logic [15:0] cur;
    if (rst_n && !mem_ce_n && mem_we_n && prev_we == 1'b0) begin
      cur = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0000;
      sram[int'(mem_addr)] = (cur & ~lane_bits(~mem_be_n)) | (mem_dq_out & lane_bits(~mem_be_n));
    end
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      cur = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 16'h0000;
      mem_dq_in = (cur & lane_bits(~mem_be_n)) | (16'hA5A5 & ~lane_bits(~mem_be_n));
    end else begin
      mem_dq_in = 16'hA5A5;
    end
  end

  // Monitor: pin timing and response scoreboard.
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_dq = 1'b0, prev_rel = 1'b0;
  logic prev_idle_all = 1'b1;
  int   we_run = 0, oe_run = 0;
  logic [15:0] hold_addr;
  logic [1:0]  hold_be;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(!((!mem_we_n) && (!mem_oe_n)), "R9 strobe/oe overlap", {mem_we_n, mem_oe_n}, 0);
      check(!(mem_dq_oe && mem_ce_n), "R9 drive while deselected", 32'(mem_dq_oe), 0);
      if (req_ready)
        check(mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n), "R2 ready while enabled",
              {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'h1f);
      if (!mem_ce_n && prev_ce) begin
        check(prev_idle_all, "R8 idle cycle before access", 32'(prev_idle_all), 1);
        check(mem_addr == last_addr, "R4 address", mem_addr, last_addr);
        check(mem_be_n == ~last_mask, "R4 lane enables", mem_be_n, ~last_mask);
        hold_addr = mem_addr; hold_be = mem_be_n;
      end else if (!mem_ce_n) begin
        check(mem_addr == hold_addr && mem_be_n == hold_be, "R7 stable during access",
              {mem_addr, mem_be_n}, {hold_addr, hold_be});
      end
      if (!mem_we_n) we_run++;
      if (mem_dq_oe && !prev_dq)
        check(!mem_we_n && we_run == EXP_TURN + 1, "R3 drive start", we_run, EXP_TURN + 1);
      if (mem_we_n && !prev_we) begin
        check(we_run == EXP_WR, "R10 strobe length", we_run, EXP_WR);
        check(mem_dq_oe && !mem_ce_n, "R3 drive held at strobe end", {mem_dq_oe, mem_ce_n}, 2'b10);
        check(mem_dq_out == last_wdata, "R3 driven word", mem_dq_out, last_wdata);
        we_run = 0;
      end
      if (prev_rel) check(!mem_dq_oe, "R3 release", 32'(mem_dq_oe), 0);
      prev_rel = mem_we_n && !prev_we && !mem_ce_n;
      if (!mem_oe_n) oe_run++;
      if (mem_oe_n && !prev_oe) begin
        check(oe_run == EXP_RD, "R10 read length", oe_run, EXP_RD);
        check(mem_we_n == 1'b1, "R5 strobe high in read", 32'(mem_we_n), 1);
        oe_run = 0;
      end
      check(rsp_valid == (mem_oe_n && !prev_oe), "R5 response timing", 32'(rsp_valid),
            32'(mem_oe_n && !prev_oe));
      if (rsp_valid) begin
        if (expq.size() == 0) check(1'b0, "R5 unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          check(rsp_rdata == e, "R5/R6 read data", rsp_rdata, e);
        end
      end
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n; prev_dq = mem_dq_oe;
      prev_idle_all = mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe, "R1 pins in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'h3e);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 handshake after reset", {req_ready, rsp_valid}, 2'b10);
    check(mem_ce_n && !mem_dq_oe, "R1 idle pins after reset", {mem_ce_n, mem_dq_oe}, 2'b10);

    access(1'b1, 16'h0005, 16'h1234, 2'b11);
    access(1'b0, 16'h0005, 16'h0000, 2'b11);
    access(1'b1, 16'h0005, 16'hAB77, 2'b01);   // R4 low lane only
    access(1'b0, 16'h0005, 16'h0000, 2'b11);
    access(1'b1, 16'h0005, 16'h99CC, 2'b10);   // R4 high lane only
    access(1'b0, 16'h0005, 16'h0000, 2'b01);   // R5 high lane zeroed
    access(1'b0, 16'h0005, 16'h0000, 2'b10);   // R5 low lane zeroed
    access(1'b0, 16'h0005, 16'h0000, 2'b00);   // R6 read returns zero
    access(1'b1, 16'h0005, 16'hFFFF, 2'b00);   // R6 write has no effect
    access(1'b0, 16'h0005, 16'h0000, 2'b11);
    access(1'b1, 16'h0000, 16'h0F0F, 2'b11);
    access(1'b1, 16'hFFFF, 16'hC3A1, 2'b11);
    access(1'b0, 16'hFFFF, 16'h0000, 2'b11);
    access(1'b0, 16'h0000, 16'h0000, 2'b11);
    for (int i = 0; i < 8; i++) access(1'b1, 16'(16'h0100 + i), 16'(i * 16'h1111), 2'b11);
    for (int i = 0; i < 8; i++) access(1'b0, 16'(16'h0100 + i), 16'h0000, 2'(i % 4));

    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R5 all responses seen", expq.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule